// File: doc/BRIEF.md
# Register-mapped AUX request engine

This block sits behind a byte-wide register port and lets a host run display auxiliary-channel transactions one at a time. The host programs a 20-bit target address, a 4-bit request code and a payload length. For a write it loads the payload bytes into an internal buffer. It then sets a start bit and polls until that bit drops. The engine presents the request on an abstract downstream link port. That port is a valid/ready request handshake followed by a single reply beat, and it stands in for the physical line.

When the link answers with a deferral, the engine retries the whole request by itself up to a parameter limit. Only the final outcome reaches the host. That outcome is a status byte whose top three bits hold a completion code and whose low five bits hold the reply byte count. Read data delivered by the link is queued in a read FIFO that the host drains one byte per register read. A separate cycle counter ends any attempt that the link never answers.

A channel-clear command empties both buffers, zeroes the status and abandons any transaction in flight. Address, request and length settings survive it.

Top module: `auxq_engine`

## Requirements
- R1: The target address is assembled from offset 0x7D (bits 7:0), 0x7E (bits 15:8) and the low nibble of 0x7F (bits 19:16). The high nibble of 0x7F is the request code. Both are presented unchanged on the link request.
- R2: Offset 0x80 bits [3:0] hold the payload length minus one, so the link length is 1 to 16. When bit 7 of 0x80 is set, the link length is 0 (address-only).
- R3: Each write to offset 0x81 appends one payload byte. Bytes beyond 16 are dropped. The link reads the payload by index, with index 0 being the first byte written since the last clear.
- R4: Each read of offset 0x82 returns and removes the oldest reply byte. A read while the FIFO is empty returns 0 and changes nothing.
- R5: Writing 1 to bit 0 of offset 0x83 starts a transaction. Bit 0 of 0x83 reads 1 while the transaction runs and 0 once it has completed.
- R6: Offset 0x84 reads {code[2:0], M[4:0]}. A link ACK (reply code 0) gives code 3 and M equal to the reply count. The status reads 0 after reset.
- R7: The only legal request codes are 0x0 (I2C write), 0x1 (I2C read), 0x8 (native write) and 0x9 (native read). Any other code completes at once with status 0x80, and no link request is made.
- R8: A link DEFER (reply code 2) is retried for up to RETRY_MAX extra attempts. If the last attempt also defers, code 2 is reported for native requests and code 6 for I2C requests.
- R9: A link NACK (reply code 1) gives code 1 for native requests and code 5 for I2C requests, with M equal to the count of bytes accepted.
- R10: If an attempt gets no reply within TIMEOUT_CYC cycles, whether or not its request was accepted, the transaction ends with status 0xE0 and the link request is withdrawn.
- R11: Writing 0xFF to offset 0x76 empties both buffers, zeroes the status and ends any running transaction. Writing any other value to 0x76 has no effect.
- R12: A link reply-byte push and a host pop in the same cycle both take effect, and the FIFO order is preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (pops FIFO at 0x82) |
| host_addr | input | 8 | Register offset |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data (combinational on host_addr) |
| lnk_req_valid | output | 1 | Request offered to the link |
| lnk_req_ready | input | 1 | Link accepts the request |
| lnk_req_cmd | output | 4 | Request code |
| lnk_req_addr | output | 20 | Target address |
| lnk_req_len | output | CNT_W (5) | Payload length in bytes, 0 for address-only |
| lnk_wr_idx | input | LEN_W (4) | Payload byte index chosen by the link |
| lnk_wr_byte | output | 8 | Payload byte at lnk_wr_idx |
| lnk_rd_push | input | 1 | Link delivers one reply byte |
| lnk_rd_byte | input | 8 | Reply byte |
| lnk_rsp_valid | input | 1 | Reply beat for the current attempt |
| lnk_rsp_code | input | 2 | 0 ACK, 1 NACK, 2 DEFER, 3 treated as NACK |
| lnk_rsp_cnt | input | 5 | Bytes accepted or returned |

## Verification
Two functions can fall in the same cycle: the link pushing a reply byte into the read FIFO and the host popping it. The bench provokes this by leaving two bytes from one read transaction in the FIFO. It then starts a second read and issues a host pop in the same cycles in which the link delivers the first two new bytes. A scoreboard queue, filled whenever the link pushes, judges every popped byte in order. A final pop on an emptied FIFO shows that the count stayed consistent.

// File: rtl/auxq_pkg.sv
`timescale 1ns/1ps
package auxq_pkg;

   // register offsets decoded by host software
   localparam logic [7:0] REG_CLR  = 8'h76;
   localparam logic [7:0] REG_A0   = 8'h7D;
   localparam logic [7:0] REG_A1   = 8'h7E;
   localparam logic [7:0] REG_A2   = 8'h7F;
   localparam logic [7:0] REG_LEN  = 8'h80;
   localparam logic [7:0] REG_WDAT = 8'h81;
   localparam logic [7:0] REG_RDAT = 8'h82;
   localparam logic [7:0] REG_CTL  = 8'h83;
   localparam logic [7:0] REG_STS  = 8'h84;
   localparam logic [7:0] CLR_KEY  = 8'hFF;

   typedef enum logic [2:0] {
      DC_NONE      = 3'd0,
      DC_NAK       = 3'd1,
      DC_DEFER     = 3'd2,
      DC_ACK       = 3'd3,
      DC_BADREQ    = 3'd4,
      DC_I2C_NAK   = 3'd5,
      DC_I2C_DEFER = 3'd6,
      DC_TIMEOUT   = 3'd7
   } done_code_e;

   typedef enum logic [1:0] {
      LK_ACK   = 2'd0,
      LK_NAK   = 2'd1,
      LK_DEFER = 2'd2,
      LK_RSVD  = 2'd3
   } link_code_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_REQ  = 2'd1,
      SQ_WAIT = 2'd2
   } seq_state_e;

   function automatic logic cmd_legal(input logic [3:0] c);
      return (c == 4'h0) || (c == 4'h1) || (c == 4'h8) || (c == 4'h9);
   endfunction

endpackage

// File: rtl/auxq_fifo.sv
`timescale 1ns/1ps
module auxq_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] head,
   input  logic [PW-1:0] peek_idx,
   output logic [DW-1:0] peek_data,
   output logic [CW-1:0] count
);

   generate
      if ((1 << PW) != DEPTH) begin : g_bad_depth
         $error("auxq_fifo: DEPTH must be a power of two");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt;
   logic          do_pop, do_push;

   assign do_pop  = pop && (cnt != '0);
   assign do_push = push && ((cnt != CW'(DEPTH)) || do_pop);

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + PW'(1);
         if (do_pop)  rd_ptr <= rd_ptr + PW'(1);
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   assign head      = (cnt != '0) ? mem[rd_ptr] : '0;
   assign peek_data = mem[rd_ptr + peek_idx];
   assign count     = cnt;

endmodule

// File: rtl/auxq_seq.sv
`timescale 1ns/1ps
module auxq_seq
   import auxq_pkg::*;
#(
   parameter int TIMEOUT_CYC = 1024,
   parameter int RETRY_MAX   = 7,
   localparam int TW = $clog2(TIMEOUT_CYC + 1),
   localparam int RW = $clog2(RETRY_MAX + 2)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       start,
   input  logic [3:0] cmd,
   output logic       req_valid,
   input  logic       req_ready,
   input  logic       rsp_valid,
   input  logic [1:0] rsp_code,
   input  logic [4:0] rsp_cnt,
   output logic       busy,
   output logic [7:0] status
);

   generate
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("auxq_seq: TIMEOUT_CYC must be at least 2");
      end
      if (RETRY_MAX < 0) begin : g_bad_retry
         $error("auxq_seq: RETRY_MAX must not be negative");
      end
   endgenerate

   seq_state_e    st;
   logic [TW-1:0] tmr;
   logic [RW-1:0] tries;
   logic          native;
   link_code_e    code_in;

   assign code_in = link_code_e'(rsp_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= SQ_IDLE; tmr <= '0; tries <= '0; native <= 1'b0; status <= '0;
      end else if (clr) begin
         st <= SQ_IDLE; tmr <= '0; tries <= '0; native <= 1'b0; status <= '0;
      end else begin
         case (st)
            SQ_IDLE: begin
               if (start) begin
                  tmr    <= '0;
                  tries  <= '0;
                  native <= cmd[3];
                  if (cmd_legal(cmd)) begin
                     status <= '0;
                     st     <= SQ_REQ;
                  end else begin
                     status <= {DC_BADREQ, 5'd0};
                  end
               end
            end
            default: begin
               if (st == SQ_WAIT && rsp_valid) begin
                  case (code_in)
                     LK_ACK: begin
                        status <= {DC_ACK, rsp_cnt};
                        st     <= SQ_IDLE;
                     end
                     LK_DEFER: begin
                        if (tries < RW'(RETRY_MAX)) begin
                           tries <= tries + RW'(1);
                           tmr   <= '0;
                           st    <= SQ_REQ;
                        end else begin
                           status <= {native ? DC_DEFER : DC_I2C_DEFER, rsp_cnt};
                           st     <= SQ_IDLE;
                        end
                     end
                     default: begin
                        status <= {native ? DC_NAK : DC_I2C_NAK, rsp_cnt};
                        st     <= SQ_IDLE;
                     end
                  endcase
               end else if (tmr == TW'(TIMEOUT_CYC - 1)) begin
                  status <= {DC_TIMEOUT, 5'd0};
                  st     <= SQ_IDLE;
               end else begin
                  tmr <= tmr + TW'(1);
                  if (st == SQ_REQ && req_ready) st <= SQ_WAIT;
               end
            end
         endcase
      end
   end

   assign req_valid = (st == SQ_REQ);
   assign busy      = (st != SQ_IDLE);

endmodule

// File: rtl/auxq_engine.sv
`timescale 1ns/1ps
module auxq_engine
   import auxq_pkg::*;
#(
   parameter int MAX_LEN     = 16,
   parameter int TIMEOUT_CYC = 1024,
   parameter int RETRY_MAX   = 7,
   localparam int LEN_W = $clog2(MAX_LEN),
   localparam int CNT_W = $clog2(MAX_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr,
   input  logic             host_rd,
   input  logic [7:0]       host_addr,
   input  logic [7:0]       host_wdata,
   output logic [7:0]       host_rdata,
   output logic             lnk_req_valid,
   input  logic             lnk_req_ready,
   output logic [3:0]       lnk_req_cmd,
   output logic [19:0]      lnk_req_addr,
   output logic [CNT_W-1:0] lnk_req_len,
   input  logic [LEN_W-1:0] lnk_wr_idx,
   output logic [7:0]       lnk_wr_byte,
   input  logic             lnk_rd_push,
   input  logic [7:0]       lnk_rd_byte,
   input  logic             lnk_rsp_valid,
   input  logic [1:0]       lnk_rsp_code,
   input  logic [4:0]       lnk_rsp_cnt
);

   generate
      if (MAX_LEN < 2 || MAX_LEN > 16) begin : g_bad_len
         $error("auxq_engine: MAX_LEN must lie in 2..16 to fit the length field");
      end
   endgenerate

   logic [7:0] addr_lo, addr_mid, addr_hi, len_reg;
   logic       chan_clr, go, wpush, rpop, busy;
   logic [7:0] sts;
   logic [7:0] rbuf_head, wbuf_head, rbuf_peek;
   logic [CNT_W-1:0] wbuf_cnt, rbuf_cnt;

   assign chan_clr = host_wr && (host_addr == REG_CLR) && (host_wdata == CLR_KEY);
   assign go       = host_wr && (host_addr == REG_CTL) && host_wdata[0];
   assign wpush    = host_wr && (host_addr == REG_WDAT);
   assign rpop     = host_rd && (host_addr == REG_RDAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_lo <= '0; addr_mid <= '0; addr_hi <= '0; len_reg <= '0;
      end else if (host_wr) begin
         case (host_addr)
            REG_A0:  addr_lo  <= host_wdata;
            REG_A1:  addr_mid <= host_wdata;
            REG_A2:  addr_hi  <= host_wdata;
            REG_LEN: len_reg  <= host_wdata;
            default: ;
         endcase
      end
   end

   auxq_fifo #(.DW(8), .DEPTH(MAX_LEN)) wbuf_i (
      .clk(clk), .rst_n(rst_n), .clr(chan_clr),
      .push(wpush), .din(host_wdata), .pop(1'b0), .head(wbuf_head),
      .peek_idx(lnk_wr_idx), .peek_data(lnk_wr_byte), .count(wbuf_cnt)
   );

   auxq_fifo #(.DW(8), .DEPTH(MAX_LEN)) rbuf_i (
      .clk(clk), .rst_n(rst_n), .clr(chan_clr),
      .push(lnk_rd_push), .din(lnk_rd_byte), .pop(rpop), .head(rbuf_head),
      .peek_idx('0), .peek_data(rbuf_peek), .count(rbuf_cnt)
   );

   logic unused_fifo_taps;
   assign unused_fifo_taps = ^{wbuf_head, rbuf_peek, wbuf_cnt, rbuf_cnt};

   auxq_seq #(.TIMEOUT_CYC(TIMEOUT_CYC), .RETRY_MAX(RETRY_MAX)) seq_i (
      .clk(clk), .rst_n(rst_n), .clr(chan_clr), .start(go), .cmd(addr_hi[7:4]),
      .req_valid(lnk_req_valid), .req_ready(lnk_req_ready),
      .rsp_valid(lnk_rsp_valid), .rsp_code(lnk_rsp_code), .rsp_cnt(lnk_rsp_cnt),
      .busy(busy), .status(sts)
   );

   assign lnk_req_cmd  = addr_hi[7:4];
   assign lnk_req_addr = {addr_hi[3:0], addr_mid, addr_lo};
   assign lnk_req_len  = len_reg[7] ? '0
                       : CNT_W'(len_reg[LEN_W-1:0]) + CNT_W'(1);

   always_comb begin
      case (host_addr)
         REG_A0:   host_rdata = addr_lo;
         REG_A1:   host_rdata = addr_mid;
         REG_A2:   host_rdata = addr_hi;
         REG_LEN:  host_rdata = len_reg;
         REG_RDAT: host_rdata = rbuf_head;
         REG_CTL:  host_rdata = {7'd0, busy};
         REG_STS:  host_rdata = sts;
         default:  host_rdata = '0;
      endcase
   end

endmodule

// File: rtl/auxq_engine_chk.sv
`timescale 1ns/1ps
module auxq_engine_chk
   import auxq_pkg::*;
#(
   parameter int TIMEOUT_CYC = 1024,
   parameter int RETRY_MAX   = 7
) (
   input logic       clk,
   input logic       rst_n,
   input logic       clr,
   input logic       start,
   input logic [3:0] cmd,
   input logic       busy,
   input logic       req_valid,
   input logic [7:0] status
);

   localparam int RUN_LIMIT = (RETRY_MAX + 1) * (TIMEOUT_CYC + 1);

   int busy_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= 0;
      else if (busy) busy_run <= busy_run + 1;
      else           busy_run <= 0;
   end

   // R5: a legal start makes the engine busy
   a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && !clr && cmd_legal(cmd) |=> busy);

   // R7: an illegal code finishes at once with the invalid code
   a_r7_bad_request: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && !clr && !cmd_legal(cmd) |=> !busy && status[7:5] == 3'd4);

   // R7: no request reaches the link outside a transaction
   a_r7_req_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> busy);

   // R11: clearing ends the transaction and zeroes the status
   a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !busy && status == 8'd0);

   // R6: every completion that is not a clear leaves a nonzero code
   a_r6_done_code: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) && !$past(clr) |-> status[7:5] != 3'd0);

   // R10: a transaction never outlives all attempts timing out
   a_r10_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> busy_run < RUN_LIMIT);

endmodule

bind auxq_engine auxq_engine_chk chk_i (
   .clk(clk), .rst_n(rst_n), .clr(chan_clr), .start(go),
   .cmd(addr_hi[7:4]), .busy(busy), .req_valid(lnk_req_valid), .status(sts)
);

// File: tb/auxq_engine_tb_top.sv
`timescale 1ns/1ps
module auxq_engine_tb_top;

   localparam int TO = 40;
   localparam int RM = 2;
   localparam logic [7:0] O_CLR = 8'h76, O_A0 = 8'h7D, O_A1 = 8'h7E, O_A2 = 8'h7F,
                          O_LEN = 8'h80, O_WD = 8'h81, O_RD = 8'h82, O_CTL = 8'h83,
                          O_STS = 8'h84;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic       host_wr, host_rd;
   logic [7:0] host_addr, host_wdata, host_rdata;
   logic       lnk_req_valid, lnk_req_ready;
   logic [3:0] lnk_req_cmd;
   logic [19:0] lnk_req_addr;
   logic [4:0] lnk_req_len;
   logic [3:0] lnk_wr_idx;
   logic [7:0] lnk_wr_byte;
   logic       lnk_rd_push;
   logic [7:0] lnk_rd_byte;
   logic       lnk_rsp_valid;
   logic [1:0] lnk_rsp_code;
   logic [4:0] lnk_rsp_cnt;

   auxq_engine #(.MAX_LEN(16), .TIMEOUT_CYC(TO), .RETRY_MAX(RM)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .lnk_req_valid(lnk_req_valid), .lnk_req_ready(lnk_req_ready),
      .lnk_req_cmd(lnk_req_cmd), .lnk_req_addr(lnk_req_addr), .lnk_req_len(lnk_req_len),
      .lnk_wr_idx(lnk_wr_idx), .lnk_wr_byte(lnk_wr_byte),
      .lnk_rd_push(lnk_rd_push), .lnk_rd_byte(lnk_rd_byte),
      .lnk_rsp_valid(lnk_rsp_valid), .lnk_rsp_code(lnk_rsp_code), .lnk_rsp_cnt(lnk_rsp_cnt)
   );

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // link model controls and captures
   logic       lk_ready = 1'b1;
   int         lk_defers = 0;
   logic [1:0] lk_final = 2'd0;
   logic [4:0] lk_cnt = 5'd0;
   int         lk_nbytes = 0;
   logic [7:0] lk_seed = 8'h00;
   bit         lk_overlap = 1'b0;
   int         lk_att = 0;
   int         lk_reqs = 0;
   int         pay_err = 0;
   logic [3:0] cap_cmd;
   logic [19:0] cap_addr;
   logic [4:0] cap_len;
   logic [7:0] exp_pay [16];
   logic [7:0] exp_q [$];

   assign lnk_req_ready = lk_ready;

   // downstream link model; also feeds the scoreboard queue
   initial begin
      lnk_wr_idx = '0; lnk_rd_push = 1'b0; lnk_rd_byte = '0;
      lnk_rsp_valid = 1'b0; lnk_rsp_code = '0; lnk_rsp_cnt = '0;
      forever begin
         if (lnk_req_valid !== 1'b1 || !lk_ready) begin
            @(negedge clk);
            continue;
         end
         lk_reqs++;
         lk_att++;
         cap_cmd = lnk_req_cmd; cap_addr = lnk_req_addr; cap_len = lnk_req_len;
         if (!cap_cmd[0]) begin
            for (int k = 0; k < int'(cap_len); k++) begin
               lnk_wr_idx = 4'(k);
               #1;
               if (lnk_wr_byte !== exp_pay[k]) pay_err++;
            end
         end
         @(negedge clk);
         if (lk_att <= lk_defers) begin
            lnk_rsp_code = 2'd2;
         end else begin
            lnk_rsp_code = lk_final;
            if (cap_cmd[0]) begin
               for (int k = 0; k < lk_nbytes; k++) begin
                  logic [7:0] b;
                  b = lk_seed + 8'(k);
                  lnk_rd_push = 1'b1;
                  lnk_rd_byte = b;
                  exp_q.push_back(b);
                  if (lk_overlap && k < 2) begin
                     logic [7:0] e;
                     host_addr = O_RD;
                     host_rd = 1'b1;
                     #1;
                     e = exp_q.pop_front();
                     chk("R12 pop while link pushes", host_rdata, e);
                  end
                  @(negedge clk);
                  lnk_rd_push = 1'b0;
                  if (lk_overlap) host_rd = 1'b0;
               end
            end
         end
         lnk_rsp_cnt = lk_cnt;
         lnk_rsp_valid = 1'b1;
         @(negedge clk);
         lnk_rsp_valid = 1'b0;
      end
   end

   task automatic hw(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hr(input logic [7:0] a, output logic [7:0] v);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 v = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic setup(input logic [19:0] ad, input logic [3:0] c, input logic [7:0] ln);
      hw(O_A0, ad[7:0]);
      hw(O_A1, ad[15:8]);
      hw(O_A2, {c, ad[19:16]});
      hw(O_LEN, ln);
   endtask

   task automatic load(input int n, input logic [7:0] seed);
      for (int k = 0; k < n; k++) begin
         if (k < 16) exp_pay[k] = seed + 8'(k);
         hw(O_WD, seed + 8'(k));
      end
   endtask

   task automatic wait_idle();
      logic [7:0] v;
      int n = 0;
      do begin
         hr(O_CTL, v);
         n++;
      end while (v[0] && n < 2000);
   endtask

   task automatic run();
      lk_att = 0; pay_err = 0;
      hw(O_CTL, 8'h01);
      wait_idle();
   endtask

   task automatic clear();
      hw(O_CLR, 8'hFF);
      exp_q.delete();
   endtask

   task automatic pop_chk(input string req);
      logic [7:0] v, e;
      hr(O_RD, v);
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
      chk(req, v, e);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int r0;
      host_wr = 1'b0; host_rd = 1'b0; host_addr = O_STS; host_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      hr(O_CTL, v); chk("R5 ctl after reset", v, 8'h00);
      hr(O_STS, v); chk("R6 status after reset", v, 8'h00);

      // native write, 4 bytes, ACK
      clear();
      setup(20'hABCDE, 4'h8, 8'h03);
      load(4, 8'h11);
      lk_final = 2'd0; lk_cnt = 5'd4; lk_defers = 0;
      lk_att = 0; pay_err = 0;
      hw(O_CTL, 8'h01);
      hr(O_CTL, v); chk("R5 busy while running", v, 8'h01);
      wait_idle();
      chk("R1 link address", cap_addr, 20'hABCDE);
      chk("R1 link command", cap_cmd, 4'h8);
      chk("R2 link length", cap_len, 5'd4);
      chk("R3 payload bytes", pay_err, 0);
      hr(O_STS, v); chk("R6 ack status", v, 8'h64);
      hr(O_CTL, v); chk("R5 start bit self-clears", v, 8'h00);

      // native read, 3 bytes
      clear();
      setup(20'h00123, 4'h9, 8'h02);
      lk_nbytes = 3; lk_cnt = 5'd3; lk_seed = 8'hA0;
      run();
      hr(O_STS, v); chk("R6 read ack status", v, 8'h63);
      pop_chk("R4 pop byte 0");
      pop_chk("R4 pop byte 1");
      pop_chk("R4 pop byte 2");
      pop_chk("R4 pop on empty gives 0");
      hr(O_STS, v); chk("R4 empty pop leaves status", v, 8'h63);

      // address-only I2C write
      clear();
      setup(20'h50000, 4'h0, 8'h85);
      lk_cnt = 5'd0;
      run();
      chk("R2 address-only length", cap_len, 5'd0);
      chk("R1 high address nibble", cap_addr, 20'h50000);
      hr(O_STS, v); chk("R6 address-only ack", v, 8'h60);

      // illegal request code
      r0 = lk_reqs;
      setup(20'h00001, 4'h5, 8'h00);
      run();
      hr(O_STS, v); chk("R7 invalid status", v, 8'h80);
      chk("R7 no link request", lk_reqs, r0);

      // two deferrals then ACK
      clear();
      setup(20'h00010, 4'h8, 8'h00);
      load(1, 8'h5A);
      lk_defers = 2; lk_final = 2'd0; lk_cnt = 5'd1;
      run();
      chk("R8 attempts with retry", lk_att, 3);
      hr(O_STS, v); chk("R8 ack after deferrals", v, 8'h61);

      // retries exhausted, native then I2C
      lk_defers = 99; lk_cnt = 5'd0;
      run();
      chk("R8 attempts before giving up", lk_att, RM + 1);
      hr(O_STS, v); chk("R8 native defer final", v, 8'h40);
      setup(20'h00010, 4'h1, 8'h00);
      lk_nbytes = 1;
      run();
      hr(O_STS, v); chk("R8 i2c defer final", v, 8'hC0);
      lk_defers = 0;

      // NACK with partial count
      setup(20'h00020, 4'h8, 8'h00);
      lk_final = 2'd1; lk_cnt = 5'd2;
      run();
      hr(O_STS, v); chk("R9 native nack", v, 8'h22);
      setup(20'h00020, 4'h0, 8'h00);
      lk_cnt = 5'd1;
      run();
      hr(O_STS, v); chk("R9 i2c nack", v, 8'hA1);
      lk_final = 2'd0;

      // timeout: link never accepts
      lk_ready = 1'b0;
      run();
      hr(O_STS, v); chk("R10 timeout status", v, 8'hE0);
      chk("R10 request withdrawn", lnk_req_valid, 1'b0);

      // clear: other key ignored, 0xFF clears, clear aborts a running transaction
      lk_ready = 1'b1;
      clear();
      setup(20'h00030, 4'h9, 8'h03);
      lk_nbytes = 4; lk_cnt = 5'd4; lk_seed = 8'hC0;
      run();
      hw(O_CLR, 8'h12);
      hr(O_STS, v); chk("R11 non-key write ignored", v, 8'h64);
      clear();
      hr(O_STS, v); chk("R11 status cleared", v, 8'h00);
      pop_chk("R11 read fifo emptied");
      lk_ready = 1'b0;
      hw(O_CTL, 8'h01);
      hw(O_CLR, 8'hFF);
      hr(O_CTL, v); chk("R11 clear aborts", v, 8'h00);
      lk_ready = 1'b1;

      // write buffer overflow: 17 pushes, first 16 kept
      clear();
      setup(20'h00040, 4'h8, 8'h0F);
      load(17, 8'h30);
      lk_cnt = 5'd16;
      run();
      chk("R3 overflow keeps first 16", pay_err, 0);
      chk("R2 full length", cap_len, 5'd16);

      // same-cycle push and pop
      clear();
      setup(20'h00050, 4'h9, 8'h03);
      lk_nbytes = 4; lk_cnt = 5'd4; lk_seed = 8'h70;
      run();
      pop_chk("R4 first read byte 0");
      pop_chk("R4 first read byte 1");
      setup(20'h00050, 4'h9, 8'h02);
      lk_nbytes = 3; lk_cnt = 5'd3; lk_seed = 8'h90; lk_overlap = 1'b1;
      lk_att = 0;
      hw(O_CTL, 8'h01);
      repeat (30) @(negedge clk);
      lk_overlap = 1'b0;
      hr(O_STS, v); chk("R12 second read status", v, 8'h63);
      pop_chk("R12 remaining byte 0");
      pop_chk("R12 remaining byte 1");
      pop_chk("R12 remaining byte 2");
      pop_chk("R12 fifo empty afterwards");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule